// File: doc/BRIEF.md
# Multi-Level Interrupt Dispatch Controller

This block sits next to a processor's fetch stage and decides, every clock, whether the highest pending interrupt level is accepted. When it is, the block updates the status register it owns and writes the saved-state registers. It also records a cause code for level-1 events and produces the fetch address of the handler, together with a one-cycle strobe that marks the redirect.

Level 1 has no vector of its own. It is folded into one of three general exception entries: user, kernel or double. Which one is chosen depends on the status mode bits. Levels 2 and above each have their own vector. Each of these levels also has its own saved-PC and saved-status slot, and taking one raises the current level in the status word. Vector targets may be relocated at run time from a vector-base input. The instruction side writes the status word through a load port.

Top module: `irq_dispatch_ctrl`

## Requirements
- R1: While reset is asserted and just after it, status reads 0x1F with IRQ_OPT=1 and 0x10 with IRQ_OPT=0. The new PC reads RESET_VEC. Cause, saved PCs, saved status words and double PC read 0, taken reads 0 and kind reads 0. The sampled pending level is cleared, so a level presented during reset causes no take.
- R2: A level L is taken only when all of these hold: L is above the effective current level, L is at most NLEVEL, and (mask of level L) AND int_set AND int_en is nonzero. The mask of level L is slice L-1 of lvl_mask_i. The effective current level is status bits [3:0]. When status bit 4 is set, it is raised to EXCM_LEVEL if EXCM_LEVEL is larger. Level 0 is never taken.
- R3: irq_level_i is registered once, and the decision uses that registered value. All updates happen on the following edge. taken_o is high for the one cycle after a take edge. kind_o then reads 1 for user, 2 for kernel, 3 for double and 4 for high level, and 0 in every other cycle.
- R4: On a take of level L≥2, slot L-1 of epc_o receives pc_i and slot L-2 of eps_o receives the status word as it was before the take.
- R5: On a take of level L≥2, status bits [3:0] become L, bit 4 is set and the other bits are kept. On a level-1 take, bit 4 is set and the other bits are kept.
- R6: On a level-1 take, cause_o becomes LVL1_CAUSE (default 4). A high-level take leaves cause_o unchanged.
- R7: A level-1 take with status bit 4 clear stores pc_i in slot 0 of epc_o. Its kind is user when status bit 5 is set and kernel otherwise.
- R8: A level-1 take with status bit 4 set is a double exception. With HAS_DEPC=1 it stores pc_i in depc_o and leaves slot 0 of epc_o unchanged. With HAS_DEPC=0 it stores pc_i in slot 0 of epc_o.
- R9: The new PC after a take is base + offset. The offset is 0x340 for user, 0x300 for kernel, 0x3C0 for double and 0x180 + (L-2)·0x40 for level L≥2. The base is vecbase_i with RELOC=1 and 0x4000_0000 with RELOC=0.
- R10: When ps_wr_en_i is high, status takes ps_wr_data_i on that edge and no take happens on that edge.
- R11: On an edge with no take and no status load, status, cause, new PC and all saved registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_level_i | input | 4 | Highest pending interrupt level, 0 for none |
| int_set_i | input | NIRQ | Raised interrupt lines |
| int_en_i | input | NIRQ | Interrupt enable mask |
| lvl_mask_i | input | NLEVEL·NIRQ | Per-level line masks, level L in slice L-1 |
| pc_i | input | AW | Current PC |
| vecbase_i | input | AW | Run-time vector base |
| ps_wr_en_i | input | 1 | Status load strobe |
| ps_wr_data_i | input | 8 | Status load value |
| status_o | output | 8 | Status register |
| epc_o | output | NLEVEL·AW | Saved PCs, level L in slice L-1 |
| eps_o | output | (NLEVEL-1)·8 | Saved status words, level L in slice L-2 |
| depc_o | output | AW | Double-exception saved PC |
| cause_o | output | CAUSE_W | Exception cause |
| kind_o | output | 3 | Kind of the take just made |
| new_pc_o | output | AW | Next fetch address |
| taken_o | output | 1 | One-cycle take strobe |

## Verification
The bench builds two copies with six levels and eight lines, driven by the same inputs. The first uses EXCM_LEVEL=0, a double PC register, relocation and the interrupt-option reset value. With EXCM_LEVEL=0, level 1 can be taken while exception mode is set, so the double path becomes reachable. The second uses EXCM_LEVEL=2, no double PC register, fixed vectors and the 0x10 reset value. Here the exception-mode floor blocks level 2 while level 3 still passes, and the fixed vector base must ignore vecbase_i.

// File: rtl/irqd_pkg.sv
`timescale 1ns/1ps
package irqd_pkg;

    localparam int PS_W    = 8;
    localparam int LVL_W   = 4;
    localparam int PS_EXCM = 4;
    localparam int PS_UM   = 5;

    typedef enum logic [2:0] {
        KIND_NONE   = 3'd0,
        KIND_USER   = 3'd1,
        KIND_KERNEL = 3'd2,
        KIND_DOUBLE = 3'd3,
        KIND_HIGH   = 3'd4
    } exc_kind_e;

    typedef struct packed {
        logic             take;
        logic [LVL_W-1:0] level;
        exc_kind_e        kind;
    } dispatch_t;

    // Level currently masking interrupts, with the exception-mode floor applied
    function automatic logic [LVL_W-1:0] eff_level(input logic [PS_W-1:0]  ps,
                                                   input logic [LVL_W-1:0] floor_lvl);
        logic [LVL_W-1:0] r;
        r = ps[LVL_W-1:0];
        if (ps[PS_EXCM] && (floor_lvl > r)) r = floor_lvl;
        return r;
    endfunction

    // Exception class a level-1 request turns into
    function automatic exc_kind_e level1_kind(input logic [PS_W-1:0] ps);
        exc_kind_e k;
        if (ps[PS_EXCM])    k = KIND_DOUBLE;
        else if (ps[PS_UM]) k = KIND_USER;
        else                k = KIND_KERNEL;
        return k;
    endfunction

    // Status word after a take
    function automatic logic [PS_W-1:0] next_status(input logic [PS_W-1:0] ps,
                                                    input dispatch_t       d);
        logic [PS_W-1:0] r;
        r = ps;
        r[PS_EXCM] = 1'b1;
        if (d.kind == KIND_HIGH) r[LVL_W-1:0] = d.level;
        return r;
    endfunction

endpackage

// File: rtl/irqd_gate.sv
`timescale 1ns/1ps
module irqd_gate
    import irqd_pkg::*;
#(
    parameter int NLEVEL     = 6,
    parameter int NIRQ       = 16,
    parameter int EXCM_LEVEL = 1
)(
    input  logic [LVL_W-1:0]       pend_lvl,
    input  logic [PS_W-1:0]        status,
    input  logic [NIRQ-1:0]        int_set,
    input  logic [NIRQ-1:0]        int_en,
    input  logic [NLEVEL*NIRQ-1:0] lvl_mask,
    input  logic                   block,
    output dispatch_t              dec
);
    localparam logic [LVL_W-1:0] FLOOR = LVL_W'(EXCM_LEVEL);
    localparam logic [LVL_W-1:0] TOP   = LVL_W'(NLEVEL);

    logic [NIRQ-1:0] live;
    logic [NLEVEL:0] lvl_hit;
    logic            in_range;
    logic            above;
    logic            hit;

    assign live       = int_set & int_en;
    assign lvl_hit[0] = 1'b0;

    for (genvar g = 1; g <= NLEVEL; g++) begin : g_hit
        assign lvl_hit[g] = |(lvl_mask[(g-1)*NIRQ +: NIRQ] & live);
    end

    always_comb begin
        in_range = (pend_lvl != '0) && (pend_lvl <= TOP);
        above    = pend_lvl > eff_level(status, FLOOR);
        hit      = 1'b0;
        for (int i = 1; i <= NLEVEL; i++) begin
            if (pend_lvl == LVL_W'(i)) hit = lvl_hit[i];
        end
        dec.take  = in_range && above && hit && !block;
        dec.level = pend_lvl;
        dec.kind  = (pend_lvl == LVL_W'(1)) ? level1_kind(status) : KIND_HIGH;
    end

endmodule

// File: rtl/irqd_vector.sv
`timescale 1ns/1ps
module irqd_vector
    import irqd_pkg::*;
#(
    parameter int            AW       = 32,
    parameter bit            RELOC    = 1'b1,
    parameter logic [AW-1:0] DEF_BASE = 'h4000_0000,
    parameter logic [AW-1:0] HI_OFS   = 'h180,
    parameter logic [AW-1:0] STRIDE   = 'h40,
    parameter logic [AW-1:0] KERN_OFS = 'h300,
    parameter logic [AW-1:0] USER_OFS = 'h340,
    parameter logic [AW-1:0] DBL_OFS  = 'h3C0
)(
    input  dispatch_t     dec,
    input  logic [AW-1:0] vecbase,
    output logic [AW-1:0] target
);
    logic [AW-1:0] ofs;
    logic [AW-1:0] base;
    logic [AW-1:0] lvl_ext;

    assign lvl_ext = AW'(dec.level);

    always_comb begin
        case (dec.kind)
            KIND_USER:   ofs = USER_OFS;
            KIND_KERNEL: ofs = KERN_OFS;
            KIND_DOUBLE: ofs = DBL_OFS;
            default:     ofs = HI_OFS + (lvl_ext - AW'(2)) * STRIDE;
        endcase
    end

    // Relocation: configured vector minus configured base plus live base
    if (RELOC) begin : g_reloc
        assign base = vecbase;
    end else begin : g_fixed
        assign base = DEF_BASE;
    end

    assign target = base + ofs;

endmodule

// File: rtl/irqd_savebank.sv
`timescale 1ns/1ps
module irqd_savebank
    import irqd_pkg::*;
#(
    parameter int NLEVEL   = 6,
    parameter int AW       = 32,
    parameter bit HAS_DEPC = 1'b1
)(
    input  logic                       clk,
    input  logic                       rst,
    input  dispatch_t                  dec,
    input  logic [AW-1:0]              pc,
    input  logic [PS_W-1:0]            status,
    output logic [NLEVEL*AW-1:0]       epc_flat,
    output logic [(NLEVEL-1)*PS_W-1:0] eps_flat,
    output logic [AW-1:0]              depc
);
    logic l1_to_epc1;

    assign l1_to_epc1 = dec.take &&
                        ((dec.kind == KIND_USER) || (dec.kind == KIND_KERNEL) ||
                         ((dec.kind == KIND_DOUBLE) && !HAS_DEPC));

    for (genvar g = 1; g <= NLEVEL; g++) begin : g_lvl
        logic [AW-1:0] epc_q;
        if (g == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst)             epc_q <= '0;
                else if (l1_to_epc1) epc_q <= pc;
            end
        end else begin : g_high
            logic            hit;
            logic [PS_W-1:0] eps_q;
            assign hit = dec.take && (dec.kind == KIND_HIGH) &&
                         (dec.level == LVL_W'(g));
            always_ff @(posedge clk) begin
                if (rst) begin
                    epc_q <= '0;
                    eps_q <= '0;
                end else if (hit) begin
                    epc_q <= pc;
                    eps_q <= status;
                end
            end
            assign eps_flat[(g-2)*PS_W +: PS_W] = eps_q;
        end
        assign epc_flat[(g-1)*AW +: AW] = epc_q;
    end

    if (HAS_DEPC) begin : g_depc
        logic [AW-1:0] depc_q;
        always_ff @(posedge clk) begin
            if (rst)                                           depc_q <= '0;
            else if (dec.take && (dec.kind == KIND_DOUBLE))    depc_q <= pc;
        end
        assign depc = depc_q;

        AST_DOUBLE_KEEPS_EPC1: assert property (@(posedge clk) disable iff (rst)
            (dec.take && (dec.kind == KIND_DOUBLE)) |=> $stable(epc_flat[AW-1:0])); // R8
        AST_DOUBLE_SAVES_PC: assert property (@(posedge clk) disable iff (rst)
            (dec.take && (dec.kind == KIND_DOUBLE)) |=> (depc == $past(pc))); // R8
    end else begin : g_nodepc
        assign depc = '0;
    end

endmodule

// File: rtl/irq_dispatch_ctrl.sv
`timescale 1ns/1ps
module irq_dispatch_ctrl
    import irqd_pkg::*;
#(
    parameter int                 NLEVEL     = 6,
    parameter int                 NIRQ       = 16,
    parameter int                 AW         = 32,
    parameter int                 EXCM_LEVEL = 1,
    parameter bit                 HAS_DEPC   = 1'b1,
    parameter bit                 RELOC      = 1'b1,
    parameter bit                 IRQ_OPT    = 1'b1,
    parameter int                 CAUSE_W    = 6,
    parameter logic [CAUSE_W-1:0] LVL1_CAUSE = 4,
    parameter logic [AW-1:0]      RESET_VEC  = 'h4000_0000,
    parameter logic [AW-1:0]      DEF_BASE   = 'h4000_0000,
    parameter logic [AW-1:0]      HI_OFS     = 'h180,
    parameter logic [AW-1:0]      STRIDE     = 'h40,
    parameter logic [AW-1:0]      KERN_OFS   = 'h300,
    parameter logic [AW-1:0]      USER_OFS   = 'h340,
    parameter logic [AW-1:0]      DBL_OFS    = 'h3C0
)(
    input  logic                       clk,
    input  logic                       rst,
    input  logic [LVL_W-1:0]           irq_level_i,
    input  logic [NIRQ-1:0]            int_set_i,
    input  logic [NIRQ-1:0]            int_en_i,
    input  logic [NLEVEL*NIRQ-1:0]     lvl_mask_i,
    input  logic [AW-1:0]              pc_i,
    input  logic [AW-1:0]              vecbase_i,
    input  logic                       ps_wr_en_i,
    input  logic [PS_W-1:0]            ps_wr_data_i,
    output logic [PS_W-1:0]            status_o,
    output logic [NLEVEL*AW-1:0]       epc_o,
    output logic [(NLEVEL-1)*PS_W-1:0] eps_o,
    output logic [AW-1:0]              depc_o,
    output logic [CAUSE_W-1:0]         cause_o,
    output logic [2:0]                 kind_o,
    output logic [AW-1:0]              new_pc_o,
    output logic                       taken_o
);
    localparam logic [PS_W-1:0]  PS_RESET = IRQ_OPT ? PS_W'(8'h1F) : PS_W'(8'h10);
    localparam logic [LVL_W-1:0] TOP_LVL  = LVL_W'(NLEVEL);

    logic [LVL_W-1:0]   pend_q;
    logic [PS_W-1:0]    status_q;
    logic [CAUSE_W-1:0] cause_q;
    logic [AW-1:0]      pc_q;
    exc_kind_e          kind_q;
    logic               taken_q;
    dispatch_t          dec;
    logic [AW-1:0]      target;

    irqd_gate #(
        .NLEVEL     (NLEVEL),
        .NIRQ       (NIRQ),
        .EXCM_LEVEL (EXCM_LEVEL)
    ) u_gate (
        .pend_lvl (pend_q),
        .status   (status_q),
        .int_set  (int_set_i),
        .int_en   (int_en_i),
        .lvl_mask (lvl_mask_i),
        .block    (ps_wr_en_i),
        .dec      (dec)
    );

    irqd_vector #(
        .AW       (AW),
        .RELOC    (RELOC),
        .DEF_BASE (DEF_BASE),
        .HI_OFS   (HI_OFS),
        .STRIDE   (STRIDE),
        .KERN_OFS (KERN_OFS),
        .USER_OFS (USER_OFS),
        .DBL_OFS  (DBL_OFS)
    ) u_vec (
        .dec     (dec),
        .vecbase (vecbase_i),
        .target  (target)
    );

    irqd_savebank #(
        .NLEVEL   (NLEVEL),
        .AW       (AW),
        .HAS_DEPC (HAS_DEPC)
    ) u_bank (
        .clk      (clk),
        .rst      (rst),
        .dec      (dec),
        .pc       (pc_i),
        .status   (status_q),
        .epc_flat (epc_o),
        .eps_flat (eps_o),
        .depc     (depc_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q   <= '0;
            status_q <= PS_RESET;
            cause_q  <= '0;
            pc_q     <= RESET_VEC;
            kind_q   <= KIND_NONE;
            taken_q  <= 1'b0;
        end else begin
            pend_q  <= irq_level_i;
            taken_q <= dec.take;
            kind_q  <= dec.take ? dec.kind : KIND_NONE;
            if (ps_wr_en_i)    status_q <= ps_wr_data_i;
            else if (dec.take) status_q <= next_status(status_q, dec);
            if (dec.take) begin
                pc_q <= target;
                if (dec.kind != KIND_HIGH) cause_q <= LVL1_CAUSE;
            end
        end
    end

    assign status_o = status_q;
    assign cause_o  = cause_q;
    assign new_pc_o = pc_q;
    assign kind_o   = kind_q;
    assign taken_o  = taken_q;

    // Saved PC of the level now held in the status word
    logic [AW-1:0] epc_at_lvl;
    always_comb begin
        epc_at_lvl = '0;
        for (int i = 1; i <= NLEVEL; i++) begin
            if (status_q[LVL_W-1:0] == LVL_W'(i)) epc_at_lvl = epc_o[(i-1)*AW +: AW];
        end
    end

    AST_IDLE_KIND: assert property (@(posedge clk) disable iff (rst)
        !taken_o |-> (kind_o == KIND_NONE)); // R3
    AST_EXCM_AFTER_TAKE: assert property (@(posedge clk) disable iff (rst)
        taken_o |-> status_o[PS_EXCM]); // R5
    AST_L1_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (taken_o && (kind_o != KIND_HIGH)) |-> (cause_o == LVL1_CAUSE)); // R6
    AST_HI_RANGE: assert property (@(posedge clk) disable iff (rst)
        (taken_o && (kind_o == KIND_HIGH)) |->
        ((status_o[LVL_W-1:0] >= LVL_W'(2)) && (status_o[LVL_W-1:0] <= TOP_LVL))); // R2
    AST_HI_EPC: assert property (@(posedge clk) disable iff (rst)
        (taken_o && (kind_o == KIND_HIGH)) |-> (epc_at_lvl == $past(pc_i))); // R4
    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!taken_o && !$past(ps_wr_en_i)) |-> $stable(status_o)); // R11
    AST_LOAD_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        ps_wr_en_i |=> (!taken_o && (status_o == $past(ps_wr_data_i)))); // R10

endmodule

// File: tb/irq_dispatch_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_dispatch_ctrl_tb_top;

    localparam int NL = 6;
    localparam int NI = 8;
    localparam int AW = 32;
    localparam int EXL  [2] = '{0, 2};
    localparam int HDP  [2] = '{1, 0};
    localparam int RLC  [2] = '{1, 0};
    localparam int IOP  [2] = '{1, 0};
    localparam logic [31:0] DEF_VB = 32'h4000_0000;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic              rst;
    logic [3:0]        irq_level_i;
    logic [NI-1:0]     int_set_i, int_en_i;
    logic [NL*NI-1:0]  lvl_mask_i;
    logic [AW-1:0]     pc_i, vecbase_i;
    logic              ps_wr_en_i;
    logic [7:0]        ps_wr_data_i;

    logic [7:0]          st    [2];
    logic [NL*AW-1:0]    epc   [2];
    logic [(NL-1)*8-1:0] eps   [2];
    logic [AW-1:0]       depc  [2];
    logic [5:0]          cause [2];
    logic [2:0]          kind  [2];
    logic [AW-1:0]       npc   [2];
    logic                tk    [2];

    irq_dispatch_ctrl #(.NLEVEL(NL), .NIRQ(NI), .AW(AW), .EXCM_LEVEL(0),
                        .HAS_DEPC(1'b1), .RELOC(1'b1), .IRQ_OPT(1'b1)) dut_i (
        .clk(clk), .rst(rst), .irq_level_i(irq_level_i), .int_set_i(int_set_i),
        .int_en_i(int_en_i), .lvl_mask_i(lvl_mask_i), .pc_i(pc_i), .vecbase_i(vecbase_i),
        .ps_wr_en_i(ps_wr_en_i), .ps_wr_data_i(ps_wr_data_i), .status_o(st[0]),
        .epc_o(epc[0]), .eps_o(eps[0]), .depc_o(depc[0]), .cause_o(cause[0]),
        .kind_o(kind[0]), .new_pc_o(npc[0]), .taken_o(tk[0]));

    irq_dispatch_ctrl #(.NLEVEL(NL), .NIRQ(NI), .AW(AW), .EXCM_LEVEL(2),
                        .HAS_DEPC(1'b0), .RELOC(1'b0), .IRQ_OPT(1'b0)) dut_b_i (
        .clk(clk), .rst(rst), .irq_level_i(irq_level_i), .int_set_i(int_set_i),
        .int_en_i(int_en_i), .lvl_mask_i(lvl_mask_i), .pc_i(pc_i), .vecbase_i(vecbase_i),
        .ps_wr_en_i(ps_wr_en_i), .ps_wr_data_i(ps_wr_data_i), .status_o(st[1]),
        .epc_o(epc[1]), .eps_o(eps[1]), .depc_o(depc[1]), .cause_o(cause[1]),
        .kind_o(kind[1]), .new_pc_o(npc[1]), .taken_o(tk[1]));

    // Reference model state
    logic [7:0]  m_ps    [2];
    logic [31:0] m_epc   [2][1:NL];
    logic [7:0]  m_eps   [2][2:NL];
    logic [31:0] m_depc  [2];
    logic [5:0]  m_cause [2];
    logic [31:0] m_npc   [2];
    logic [2:0]  m_kind  [2];
    logic        m_tk    [2];
    logic [3:0]  m_pend;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    task automatic chk(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] vec_of(input int d, input logic [2:0] k,
                                           input int lvl, input logic [31:0] vb);
        logic [31:0] base, ofs;
        base = (RLC[d] != 0) ? vb : DEF_VB;
        case (k)
            3'd1:    ofs = 32'h340;
            3'd2:    ofs = 32'h300;
            3'd3:    ofs = 32'h3C0;
            default: ofs = 32'h180 + 32'(lvl - 2) * 32'h40;
        endcase
        return base + ofs;
    endfunction

    task automatic model_reset();
        for (int d = 0; d < 2; d++) begin
            m_ps[d]    = (IOP[d] != 0) ? 8'h1F : 8'h10;
            for (int l = 1; l <= NL; l++) m_epc[d][l] = '0;
            for (int l = 2; l <= NL; l++) m_eps[d][l] = '0;
            m_depc[d]  = '0;
            m_cause[d] = '0;
            m_npc[d]   = DEF_VB;
            m_kind[d]  = 3'd0;
            m_tk[d]    = 1'b0;
        end
        m_pend = '0;
    endtask

    task automatic model_step();
        for (int d = 0; d < 2; d++) begin
            int cint, lvl;
            bit take;
            logic [2:0] k;
            logic [7:0] ps_old;
            ps_old = m_ps[d];
            lvl  = int'(m_pend);
            cint = int'(ps_old[3:0]);
            if (ps_old[4] && EXL[d] > cint) cint = EXL[d];
            take = !ps_wr_en_i && lvl > cint && lvl <= NL &&
                   ((lvl_mask_i[(lvl-1)*NI +: NI] & int_set_i & int_en_i) != '0);
            k = 3'd0;
            if (take) begin
                if (lvl == 1) k = ps_old[4] ? 3'd3 : (ps_old[5] ? 3'd1 : 3'd2);
                else          k = 3'd4;
                if (k == 3'd4) begin
                    m_epc[d][lvl] = pc_i;
                    m_eps[d][lvl] = ps_old;
                    m_ps[d] = {ps_old[7:5], 1'b1, 4'(lvl)};
                end else begin
                    m_cause[d] = 6'd4;
                    if (k == 3'd3 && HDP[d] != 0) m_depc[d] = pc_i;
                    else m_epc[d][1] = pc_i;
                    m_ps[d] = ps_old | 8'h10;
                end
                m_npc[d] = vec_of(d, k, lvl, vecbase_i);
            end
            if (ps_wr_en_i) m_ps[d] = ps_wr_data_i;
            m_kind[d] = k;
            m_tk[d]   = take;
        end
        m_pend = irq_level_i;
    endtask

    task automatic cmp_all(input string ctx);
        for (int d = 0; d < 2; d++) begin
            chk(ctx,  $sformatf("dut%0d taken", d), 32'(tk[d]), 32'(m_tk[d]));
            chk(ctx,  $sformatf("dut%0d kind", d), 32'(kind[d]), 32'(m_kind[d]));
            chk("R5", $sformatf("dut%0d status", d), 32'(st[d]), 32'(m_ps[d]));
            chk("R6", $sformatf("dut%0d cause", d), 32'(cause[d]), 32'(m_cause[d]));
            chk("R9", $sformatf("dut%0d new_pc", d), npc[d], m_npc[d]);
            chk("R8", $sformatf("dut%0d depc", d), depc[d], m_depc[d]);
            for (int l = 1; l <= NL; l++)
                chk("R4", $sformatf("dut%0d epc%0d", d, l), epc[d][(l-1)*AW +: AW], m_epc[d][l]);
            for (int l = 2; l <= NL; l++)
                chk("R4", $sformatf("dut%0d eps%0d", d, l), 32'(eps[d][(l-2)*8 +: 8]), 32'(m_eps[d][l]));
        end
    endtask

    task automatic step(input string ctx);
        model_step();
        @(posedge clk);
        @(negedge clk);
        cmp_all(ctx);
    endtask

    task automatic scenario(input logic [7:0] ps, input logic [3:0] lvl, input string ctx);
        ps_wr_en_i   = 1'b1;
        ps_wr_data_i = ps;
        irq_level_i  = lvl;
        pc_i         = $urandom;
        step("R10");
        ps_wr_en_i   = 1'b0;
        pc_i         = $urandom;
        step(ctx);
        pc_i         = $urandom;
        step(ctx);
        irq_level_i  = 4'd0;
        step(ctx);
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        rst          = 1'b1;
        irq_level_i  = 4'd3;
        int_set_i    = '1;
        int_en_i     = '1;
        lvl_mask_i   = '1;
        pc_i         = 32'h1000_0000;
        vecbase_i    = 32'h2000_0000;
        ps_wr_en_i   = 1'b0;
        ps_wr_data_i = '0;
        model_reset();
        repeat (3) @(negedge clk);
        cmp_all("R1");
        chk("R1", "dut0 status reset", 32'(st[0]), 32'h1F);
        chk("R1", "dut1 status reset", 32'(st[1]), 32'h10);
        rst = 1'b0;
        // Pending level 3 was held through reset: cleared sample means no take this edge
        step("R1");
        step("R3");

        // R10: status load wins over a ready take
        scenario(8'h00, 4'd2, "R2");
        // R2: level 3 masked off
        lvl_mask_i[2*NI +: NI] = '0;
        scenario(8'h00, 4'd3, "R2");
        lvl_mask_i = '1;
        // R2: level above NLEVEL
        scenario(8'h00, 4'd7, "R2");
        // R2: enable mask clear
        int_en_i = '0;
        scenario(8'h00, 4'd4, "R2");
        int_en_i = '1;
        // R7: kernel and user entries
        scenario(8'h00, 4'd1, "R7");
        scenario(8'h20, 4'd1, "R7");
        // R8: double in first copy, blocked by floor in second
        scenario(8'h10, 4'd1, "R8");
        // R2: exception-mode floor 2 blocks level 2, level 3 passes (second copy)
        scenario(8'h10, 4'd2, "R2");
        scenario(8'h10, 4'd3, "R2");
        // R9: relocated base
        vecbase_i = 32'h8000_0000;
        scenario(8'h00, 4'd5, "R9");
        scenario(8'h00, 4'd1, "R9");
        // R11: nothing pending
        scenario(8'h03, 4'd0, "R11");
        // R10: load held high with a pending level
        ps_wr_en_i = 1'b1; ps_wr_data_i = 8'h00; irq_level_i = 4'd4;
        step("R10"); step("R10"); step("R10");
        ps_wr_en_i = 1'b0;
        step("R10");

        for (int i = 0; i < 4000; i++) begin
            irq_level_i  = 4'($urandom_range(0, 7));
            int_set_i    = NI'($urandom) | NI'($urandom);
            int_en_i     = NI'($urandom) | NI'($urandom);
            if ($urandom_range(0, 15) == 0) lvl_mask_i = {$urandom, $urandom};
            if ($urandom_range(0, 31) == 0) vecbase_i = $urandom & 32'hFFFF_F000;
            pc_i         = $urandom;
            ps_wr_en_i   = ($urandom_range(0, 5) == 0);
            ps_wr_data_i = 8'($urandom);
            step("R3");
        end

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog act=running exp=finished");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule